// File: doc/BRIEF.md
# Multiplexed Host Bus Interface

This block is the slave end of an 8-bit parallel host bus on which address and data share the same wires. It connects a host processor to an internal register file through a simple port. That port has an address, write data, combinational read data, single-cycle write and read commit pulses, and an optional acknowledge.

The host first performs an index phase with register-select low. This either loads the internal index register from the bus or reads the index back. It then performs data phases with register-select high, which read or write the register that the index points to. A static style input selects how the strobes are read:

- **Separate-strobe style:** active-low read and write strobes.
- **Enable style:** an active-high enable plus a read/write line.

The strobe and control pins are synchronized to the core clock. The internal access is issued when the end of a strobe is detected. An active-low busy output holds the host off while the internal access completes. The host must see busy high before it starts another cycle.

The data bus is driven only during an enabled read. At all other times it is left at high impedance. A parallel-enable input must be high for any of this to happen.

Top module: `mux_host_bus_if`

## Requirements
- R1: After reset, `host_busy_n` is high, the index register is 0, and no register access has been issued.
- R2: In separate-strobe style (`host_style` = 0), a write cycle with `host_rs` low loads the index register with the bus value present while `host_wr_n` was low. An index read (`host_rs` low, `host_rd_n` low) returns it.
- R3: In separate-strobe style, a write cycle with `host_rs` high issues exactly one `reg_wr` pulse. That pulse carries `reg_addr` equal to the index and `reg_wdata` equal to the bus value.
- R4: In separate-strobe style, while `host_rd_n` is low with `host_rs` high, the bus carries `reg_rdata` for the indexed register. Exactly one `reg_rd` pulse follows the release of the strobe.
- R5: In separate-strobe style, `host_busy_n` stays high while a strobe is held. After a data-phase strobe is released, it goes low for exactly `ACCESS_LAT` clocks (fixed-latency variant). Index phases never drive it low.
- R6: In enable style (`host_style` = 1), `host_rd_n` is the active-high enable and `host_wr_n` is read/write, with 1 meaning read. An enabled cycle with read/write at 0 loads the index when `host_rs` is low, and issues one register write when `host_rs` is high. Either action takes effect when the enable falls.
- R7: In enable style, while the enable is high with read/write at 1, the bus carries the indexed register when `host_rs` is high, and the index when `host_rs` is low.
- R8: In enable style, `host_busy_n` is low while a data-phase enable is held. It stays low from the fall of the enable until the access completes, then returns high within `ACCESS_LAT` + 4 clocks.
- R9: The block never drives the bus while `host_cs_n` is high, and never drives it or issues any access while `host_par_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_par_en | input | 1 | Parallel interface enable, static |
| host_style | input | 1 | 0: separate read/write strobes, 1: enable plus read/write, static |
| host_cs_n | input | 1 | Chip select, active low |
| host_rs | input | 1 | Register select: 0 index phase, 1 data phase |
| host_rd_n | input | 1 | Read strobe (style 0) or enable, active high (style 1) |
| host_wr_n | input | 1 | Write strobe (style 0) or read/write, 1 = read (style 1) |
| host_busy_n | output | 1 | Busy, active low |
| host_data | inout | 8 | Multiplexed address/data bus |
| reg_addr | output | 8 | Register file address (the index) |
| reg_wdata | output | 8 | Register file write data |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_rd | output | 1 | One-cycle register read commit pulse |
| reg_rdata | input | 8 | Combinational register read data |
| reg_ack | input | 1 | Access done (used by the acknowledge variant) |

## Verification
The main function is driven with both bus styles and with all four combinations of register-select and direction. This shows that the index path and the data path are decoded separately, and that read/write is taken from the correct pin in each style. Index and data patterns use complementary bit values, so that a swapped byte or a stale index produces a visible mismatch. Busy is timed clock by clock: a data write and a data read must give the exact fixed latency, while an index phase must leave busy untouched. Finally, full write cycles are repeated with chip select idle and with the parallel enable low. This confirms that the bus, the index and the register contents stay unchanged under those conditions.

// File: rtl/mhb_pkg.sv
package mhb_pkg;

    typedef enum logic {
        STYLE_SPLIT  = 1'b0,
        STYLE_ENABLE = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic cs_n;
        logic rs;
        logic rd_n;
        logic wr_n;
    } host_ctl_t;

    localparam int CTL_W = $bits(host_ctl_t);

    typedef struct packed {
        logic is_data;
        logic is_write;
    } phase_t;

    // Strobe asserted for the selected bus style.
    function automatic logic strobe_on(bus_style_e style, host_ctl_t c);
        if (style == STYLE_ENABLE) return c.rd_n;
        return (!c.rd_n) || (!c.wr_n);
    endfunction

    // Host is asking the slave to drive the bus.
    function automatic logic read_window(bus_style_e style, host_ctl_t c);
        if (c.cs_n) return 1'b0;
        if (style == STYLE_ENABLE) return c.rd_n && c.wr_n;
        return !c.rd_n;
    endfunction

    // Direction of the phase in progress: a low write pin means write in both styles.
    function automatic phase_t decode_phase(host_ctl_t c);
        phase_t p;
        p.is_data  = c.rs;
        p.is_write = !c.wr_n;
        return p;
    endfunction

endpackage

// File: rtl/mhb_sync.sv
module mhb_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RST_VAL;
                    else     stage_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mhb_cycle_track.sv
module mhb_cycle_track
    import mhb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en,
    input  bus_style_e        style,
    input  host_ctl_t         ctl_s,
    input  logic [DATA_W-1:0] data_s,
    output logic [DATA_W-1:0] index_q,
    output logic              commit,
    output logic              phase_busy,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata
);
    logic              active;
    logic              active_q;
    phase_t            phase_now;
    phase_t            phase_cap;
    logic [DATA_W-1:0] data_hold;
    logic              cycle_end;
    logic              idx_load;

    assign phase_now = decode_phase(ctl_s);
    assign active    = par_en && !ctl_s.cs_n && strobe_on(style, ctl_s);
    assign cycle_end = active_q && !active;
    assign commit    = cycle_end && phase_cap.is_data;

    // Enable style keeps busy low for the whole data phase, bridging the end cycle.
    assign phase_busy = (style == STYLE_ENABLE) &&
                        ((active && phase_now.is_data) || (active_q && phase_cap.is_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            phase_cap <= '0;
            data_hold <= '0;
        end else begin
            active_q <= active;
            if (active) begin
                phase_cap <= phase_now;
                data_hold <= data_s;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q   <= '0;
            idx_load  <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            idx_load <= 1'b0;
            reg_wr   <= 1'b0;
            reg_rd   <= 1'b0;
            if (cycle_end) begin
                if (phase_cap.is_data) begin
                    reg_wr    <= phase_cap.is_write;
                    reg_rd    <= !phase_cap.is_write;
                    reg_wdata <= data_hold;
                end else if (phase_cap.is_write) begin
                    index_q  <= data_hold;
                    idx_load <= 1'b1;
                end
            end
        end
    end

    // R3: one kind of action per completed host cycle
    assert_one_action_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_wr, reg_rd, idx_load}));

    // R2: index moves only on an index load
    assert_index_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !idx_load |-> index_q == $past(index_q));
endmodule

// File: rtl/mhb_busy.sv
module mhb_busy #(
    parameter int ACCESS_LAT = 4,
    parameter bit USE_ACK    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic reg_ack,
    output logic pending
);
    localparam int CNT_W = (ACCESS_LAT < 2) ? 1 : $clog2(ACCESS_LAT);

    generate
        if (USE_ACK) begin : g_ack
            always_ff @(posedge clk) begin
                if (rst)                  pending <= 1'b0;
                else if (commit)          pending <= 1'b1;
                else if (pending && reg_ack) pending <= 1'b0;
            end
        end else begin : g_fixed
            logic [CNT_W-1:0] left_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pending <= 1'b0;
                    left_q  <= '0;
                end else if (commit) begin
                    pending <= 1'b1;
                    left_q  <= CNT_W'(ACCESS_LAT - 1);
                end else if (pending) begin
                    if (left_q == '0) pending <= 1'b0;
                    else              left_q  <= left_q - 1'b1;
                end
            end
            logic unused_ack;
            assign unused_ack = reg_ack;
        end
    endgenerate

    // R5: a completed data phase always leaves the access pending
    assert_commit_sets_busy_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> pending);

    // R5: the host never completes a new data phase while busy
    assert_no_commit_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        pending |-> !commit);
endmodule

// File: rtl/mux_host_bus_if.sv
module mux_host_bus_if
    import mhb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ACCESS_LAT  = 4,
    parameter bit USE_ACK     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_par_en,
    input  logic              host_style,
    input  logic              host_cs_n,
    input  logic              host_rs,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    output logic              host_busy_n,
    inout  wire  [DATA_W-1:0] host_data,
    output logic [DATA_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_ack
);
    bus_style_e        style;
    host_ctl_t         ctl_raw;
    host_ctl_t         ctl_s;
    logic [CTL_W-1:0]  ctl_s_bits;
    logic [DATA_W-1:0] data_s;
    logic [DATA_W-1:0] index_q;
    logic              commit;
    logic              phase_busy;
    logic              pending;
    logic              drive_en;
    logic [DATA_W-1:0] drive_val;

    assign style   = bus_style_e'(host_style);
    assign ctl_raw = '{cs_n: host_cs_n, rs: host_rs, rd_n: host_rd_n, wr_n: host_wr_n};

    mhb_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst(rst), .d_in(ctl_raw), .d_out(ctl_s_bits)
    );
    assign ctl_s = host_ctl_t'(ctl_s_bits);

    mhb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .d_in(host_data), .d_out(data_s)
    );

    mhb_cycle_track #(.DATA_W(DATA_W)) u_track (
        .clk(clk), .rst(rst), .par_en(host_par_en), .style(style),
        .ctl_s(ctl_s), .data_s(data_s), .index_q(index_q), .commit(commit),
        .phase_busy(phase_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata)
    );

    mhb_busy #(.ACCESS_LAT(ACCESS_LAT), .USE_ACK(USE_ACK)) u_busy (
        .clk(clk), .rst(rst), .commit(commit), .reg_ack(reg_ack), .pending(pending)
    );

    assign reg_addr    = index_q;
    assign host_busy_n = !(pending || phase_busy);

    // Bus drive straight from the pins so read data meets host timing.
    assign drive_en  = host_par_en && read_window(style, ctl_raw);
    assign drive_val = host_rs ? reg_rdata : index_q;
    assign host_data = drive_en ? drive_val : {DATA_W{1'bz}};

    // R9: a disabled parallel port issues no accesses
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!host_par_en && $past(!host_par_en) && $past(!host_par_en, 2)
         && $past(!host_par_en, 3) && $past(!host_par_en, 4)) |-> !(reg_wr || reg_rd));

    // R1: busy is released on leaving reset
    assert_busy_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> host_busy_n);

    // R5: a register write is always covered by busy
    assert_write_holds_busy_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !host_busy_n);
endmodule

// File: tb/tb_mux_host_bus_if.sv
module tb_mux_host_bus_if;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_par_en = 1'b1;
    logic host_style  = 1'b0;
    logic host_cs_n   = 1'b1;
    logic host_rs     = 1'b0;
    logic host_rd_n   = 1'b1;
    logic host_wr_n   = 1'b1;
    logic host_busy_n;
    wire  [7:0] host_data;
    logic [7:0] drv = 8'h00;
    logic drv_en = 1'b0;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic reg_wr, reg_rd;
    logic [7:0] mem [256];

    int n_tests = 0;
    int n_fail  = 0;
    int wr_cnt  = 0;
    int rd_cnt  = 0;
    int busy_lo = 0;

    always #2 clk = ~clk;

    assign host_data = drv_en ? drv : 8'hzz;
    assign reg_rdata = mem[reg_addr];

    mux_host_bus_if #(.ACCESS_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .host_par_en(host_par_en), .host_style(host_style),
        .host_cs_n(host_cs_n), .host_rs(host_rs), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_busy_n(host_busy_n), .host_data(host_data),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .reg_ack(1'b0)
    );

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) if (!rst && !host_busy_n) busy_lo <= busy_lo + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Separate-strobe host cycle
    task automatic split_cycle(input logic rs, input logic wr, input logic [7:0] d,
                               output logic [7:0] q, output logic busy_mid);
        @(negedge clk);
        host_rs = rs; host_cs_n = 1'b0;
        if (wr) begin drv = d; drv_en = 1'b1; host_wr_n = 1'b0; end
        else host_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        q = host_data; busy_mid = host_busy_n;
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        repeat (3) @(negedge clk);
        drv_en = 1'b0; host_cs_n = 1'b1;
        repeat (LAT + 4) @(negedge clk);
    endtask

    // Enable-style host cycle
    task automatic enable_cycle(input logic rs, input logic wr, input logic [7:0] d,
                                output logic [7:0] q, output logic busy_mid,
                                output logic busy_after);
        @(negedge clk);
        host_rs = rs; host_cs_n = 1'b0; host_wr_n = !wr;
        if (wr) begin drv = d; drv_en = 1'b1; end
        host_rd_n = 1'b1;
        repeat (5) @(negedge clk);
        q = host_data; busy_mid = host_busy_n;
        host_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        busy_after = host_busy_n;
        @(negedge clk);
        drv_en = 1'b0; host_cs_n = 1'b1; host_wr_n = 1'b1;
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] q; logic b;
        chk("R1", "busy after reset", host_busy_n, 1);
        chk("R1", "no access after reset", wr_cnt + rd_cnt, 0);
        split_cycle(1'b0, 1'b0, 8'h00, q, b);
        chk("R1", "index after reset", q, 8'h00);
    endtask

    task automatic t_split_index();
        logic [7:0] q; logic b; int lo0;
        lo0 = busy_lo;
        split_cycle(1'b0, 1'b1, 8'h33, q, b);
        chk("R5", "busy high during strobe", b, 1);
        split_cycle(1'b0, 1'b0, 8'h00, q, b);
        chk("R2", "index readback", q, 8'h33);
        chk("R5", "index phases keep busy high", busy_lo - lo0, 0);
        chk("R2", "index phase issues no access", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_split_write();
        logic [7:0] q; logic b; int lo0, w0;
        split_cycle(1'b0, 1'b1, 8'h10, q, b);
        lo0 = busy_lo; w0 = wr_cnt;
        split_cycle(1'b1, 1'b1, 8'hA7, q, b);
        chk("R5", "busy high while write strobe held", b, 1);
        chk("R3", "register written", mem[8'h10], 8'hA7);
        chk("R3", "one write pulse", wr_cnt - w0, 1);
        chk("R5", "busy low clocks after write", busy_lo - lo0, LAT);
        chk("R3", "neighbour untouched", mem[8'h11], 8'h11 ^ 8'h5A);
    endtask

    task automatic t_split_read();
        logic [7:0] q; logic b; int lo0, r0;
        split_cycle(1'b0, 1'b1, 8'h22, q, b);
        lo0 = busy_lo; r0 = rd_cnt;
        split_cycle(1'b1, 1'b0, 8'h00, q, b);
        chk("R4", "data read value", q, 8'h22 ^ 8'h5A);
        chk("R4", "one read pulse", rd_cnt - r0, 1);
        chk("R5", "busy low clocks after read", busy_lo - lo0, LAT);
    endtask

    task automatic t_enable_mode();
        logic [7:0] q; logic bm, ba; int w0;
        host_style = 1'b1; host_rd_n = 1'b0; host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        enable_cycle(1'b0, 1'b1, 8'h5C, q, bm, ba);
        chk("R8", "busy high in index phase", bm, 1);
        enable_cycle(1'b0, 1'b0, 8'h00, q, bm, ba);
        chk("R7", "index read in enable style", q, 8'h5C);
        chk("R6", "index mode no read pulse", rd_cnt, 1);
        w0 = wr_cnt;
        enable_cycle(1'b1, 1'b1, 8'h3E, q, bm, ba);
        chk("R8", "busy low while data enable held", bm, 0);
        chk("R8", "busy low after enable falls", ba, 0);
        chk("R8", "busy released", host_busy_n, 1);
        chk("R6", "enable-style write value", mem[8'h5C], 8'h3E);
        chk("R6", "enable-style one write", wr_cnt - w0, 1);
        enable_cycle(1'b0, 1'b1, 8'h07, q, bm, ba);
        enable_cycle(1'b1, 1'b0, 8'h00, q, bm, ba);
        chk("R7", "enable-style data read", q, 8'h07 ^ 8'h5A);
        host_style = 1'b0; host_rd_n = 1'b1; host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_quiet();
        logic [7:0] q; logic b; int w0;
        split_cycle(1'b0, 1'b1, 8'hC3, q, b);
        // chip select idle: a read strobe must not drive the bus
        @(negedge clk);
        host_rs = 1'b0; drv = 8'h3C; drv_en = 1'b1; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "bus released with cs high", host_data, 8'h3C);
        host_rd_n = 1'b1; drv_en = 1'b0;
        // parallel port disabled
        host_par_en = 1'b0;
        repeat (6) @(negedge clk);
        w0 = wr_cnt;
        split_cycle(1'b1, 1'b1, 8'h99, q, b);
        split_cycle(1'b0, 1'b1, 8'h44, q, b);
        @(negedge clk);
        host_cs_n = 1'b0; host_rs = 1'b0; drv = 8'h3C; drv_en = 1'b1; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "bus released when disabled", host_data, 8'h3C);
        host_rd_n = 1'b1; drv_en = 1'b0; host_cs_n = 1'b1;
        chk("R9", "no write when disabled", wr_cnt - w0, 0);
        chk("R9", "register kept when disabled", mem[8'hC3], 8'hC3 ^ 8'h5A);
        host_par_en = 1'b1;
        repeat (6) @(negedge clk);
        split_cycle(1'b0, 1'b0, 8'h00, q, b);
        chk("R9", "index kept when disabled", q, 8'hC3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_split_index();
        t_split_write();
        t_split_read();
        t_enable_mode();
        t_quiet();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule